// File: doc/BRIEF.md
# PWM Request-to-Register Quantizer

This block converts a PWM request into the two load values that a down-counting PWM generator uses. The request is a period and a high time, both given in clock cycles. The generator produces a period of `period_load + 2` cycles and a high time of `duty_load + 2` cycles. When the duty load is not below the period load, the generator's output stays low for the whole period. The quantizer applies one fixed rounding policy. The period is never made longer than requested. The duty is never made longer than requested or longer than the chosen period. A request with a period too short to build is flagged as an error.

The configured maximum count is the largest load value the generator's counter accepts, so the longest period it can produce is `max_count + 2` cycles. A caller pulses `req_valid` with a request. One cycle later `res_valid` pulses, and the load values and the error flag show the outcome. Between results the outputs keep their last values.

Top module: `pwm_req_quantizer`

## Requirements
- R1: `res_valid` is high in exactly the cycle after a cycle with `req_valid` high. In every other cycle it is low. Load values and `range_err` for a request appear in that same cycle.
- R2: A requested period above `max_count + 2` cycles is capped to `max_count + 2`, which gives `period_load = max_count`.
- R3: A capped period below 2 cycles raises `range_err` with both loads set to 0. Otherwise `range_err` is 0.
- R4: A period request from 2 to `max_count + 2` cycles gives `period_load = req_period - 2` exactly. A longer period is never chosen.
- R5: The duty request is first capped to `max_count + 2` and then to the chosen period. The result always satisfies `duty_load <= period_load`.
- R6: If the capped duty equals the chosen period, which is a 100 % request, the duty becomes one cycle less than the period, so `duty_load = period_load - 1`.
- R7: If the duty after the R5 and R6 steps is below 2 cycles, it is set equal to the period, so `duty_load = period_load`, which encodes 0 % output.
- R8: A duty from 2 to period-1 cycles gives `duty_load = req_duty - 2` exactly.
- R9: While no request is presented, `period_load`, `duty_load` and `range_err` keep their previous values. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_period | input | LOAD_W+1 | Requested period in cycles |
| req_duty | input | LOAD_W+1 | Requested high time in cycles |
| max_count | input | LOAD_W | Largest load value of the generator |
| res_valid | output | 1 | Result strobe, one cycle after the request |
| period_load | output | LOAD_W | Period load value (period = value + 2) |
| duty_load | output | LOAD_W | Duty load value (high time = value + 2) |
| range_err | output | 1 | Period request could not be met |

## Verification
The bench targets the edges where the policy changes. These are periods of 0, 1, 2 and 3 cycles, periods exactly at `max_count + 2` and one cycle past it, duties equal to the period, duties of 0, 1 and 2 cycles, and duties above the capped period. A design that rounds the period up or skips the cap would report a load above `max_count`. One that drops the 100 % fold would give `duty_load == period_load` and output a silent 0 %. One that keeps duties of 1 cycle would emit a load that wraps below zero. Idle cycles between requests show whether the outputs drift without a strobe.

// File: rtl/pwmq_pkg.sv
package pwmq_pkg;
    // Shortest period or high time, in cycles, the generator can produce.
    localparam int unsigned MIN_CYC = 2;
endpackage

// File: rtl/pwmq_period_cap.sv
module pwmq_period_cap #(
    parameter int unsigned LOAD_W = 16,
    localparam int unsigned CYC_W = LOAD_W + 1
) (
    input  logic [CYC_W-1:0]  req_period,
    input  logic [LOAD_W-1:0] max_count,
    output logic [CYC_W-1:0]  max_period,
    output logic [CYC_W-1:0]  period_cyc,
    output logic              too_short
);
    import pwmq_pkg::*;

    always_comb begin
        max_period = {1'b0, max_count} + CYC_W'(MIN_CYC);
        // round down only: cap at the longest period, never extend
        period_cyc = (req_period > max_period) ? max_period : req_period;
        too_short  = period_cyc < CYC_W'(MIN_CYC);
    end
endmodule

// File: rtl/pwmq_duty_fit.sv
module pwmq_duty_fit #(
    parameter int unsigned LOAD_W = 16,
    localparam int unsigned CYC_W = LOAD_W + 1
) (
    input  logic [CYC_W-1:0] req_duty,
    input  logic [CYC_W-1:0] max_period,
    input  logic [CYC_W-1:0] period_cyc,
    output logic [CYC_W-1:0] duty_cyc
);
    import pwmq_pkg::*;

    logic [CYC_W-1:0] lim_max;
    logic [CYC_W-1:0] lim_per;
    logic [CYC_W-1:0] folded;

    always_comb begin
        lim_max = (req_duty > max_period) ? max_period : req_duty;
        lim_per = (lim_max > period_cyc) ? period_cyc : lim_max;
        // a full-period high time is not producible: give one cycle back
        folded  = (lim_per == period_cyc) ? period_cyc - CYC_W'(1) : lim_per;
        // too short to produce: encode as no high time at all
        duty_cyc = (folded < CYC_W'(MIN_CYC)) ? period_cyc : folded;
    end
endmodule

// File: rtl/pwm_req_quantizer.sv
module pwm_req_quantizer #(
    parameter int unsigned LOAD_W = 16,
    localparam int unsigned CYC_W = LOAD_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CYC_W-1:0]  req_period,
    input  logic [CYC_W-1:0]  req_duty,
    input  logic [LOAD_W-1:0] max_count,
    output logic              res_valid,
    output logic [LOAD_W-1:0] period_load,
    output logic [LOAD_W-1:0] duty_load,
    output logic              range_err
);
    import pwmq_pkg::*;

    typedef struct packed {
        logic              vld;
        logic              err;
        logic [LOAD_W-1:0] per;
        logic [LOAD_W-1:0] dut;
    } res_t;

    res_t st_d, st_q;

    logic [CYC_W-1:0] max_period;
    logic [CYC_W-1:0] period_cyc;
    logic [CYC_W-1:0] duty_cyc;
    logic             too_short;
    logic [CYC_W-1:0] per_off;
    logic [CYC_W-1:0] dut_off;

    pwmq_period_cap #(.LOAD_W(LOAD_W)) i_cap (
        .req_period (req_period),
        .max_count  (max_count),
        .max_period (max_period),
        .period_cyc (period_cyc),
        .too_short  (too_short)
    );

    pwmq_duty_fit #(.LOAD_W(LOAD_W)) i_fit (
        .req_duty   (req_duty),
        .max_period (max_period),
        .period_cyc (period_cyc),
        .duty_cyc   (duty_cyc)
    );

    always_comb begin
        per_off = period_cyc - CYC_W'(MIN_CYC);
        dut_off = duty_cyc - CYC_W'(MIN_CYC);
        st_d     = st_q;
        st_d.vld = req_valid;
        if (req_valid) begin
            if (too_short) begin
                st_d.err = 1'b1;
                st_d.per = '0;
                st_d.dut = '0;
            end else begin
                st_d.err = 1'b0;
                st_d.per = per_off[LOAD_W-1:0];
                st_d.dut = dut_off[LOAD_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid   = st_q.vld;
    assign range_err   = st_q.err;
    assign period_load = st_q.per;
    assign duty_load   = st_q.dut;
endmodule

// File: rtl/pwmq_chk.sv
module pwmq_chk #(
    parameter int unsigned LOAD_W = 16,
    localparam int unsigned CYC_W = LOAD_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [CYC_W-1:0]  req_period,
    input logic [CYC_W-1:0]  req_duty,
    input logic [LOAD_W-1:0] max_count,
    input logic              res_valid,
    input logic [LOAD_W-1:0] period_load,
    input logic [LOAD_W-1:0] duty_load,
    input logic              range_err
);
    // R1
    res_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);
    // R1
    no_spurious_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid);
    // R2
    period_within_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (range_err || period_load <= $past(max_count)));
    // R3
    err_zero_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && range_err) |-> (period_load == '0 && duty_load == '0));
    // R4
    period_not_longer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (range_err || {1'b0, period_load} + CYC_W'(2) <= $past(req_period)));
    // R5
    duty_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> duty_load <= period_load);
    // R9
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(period_load) && $stable(duty_load) && $stable(range_err)));
endmodule

bind pwm_req_quantizer pwmq_chk #(.LOAD_W(LOAD_W)) i_chk (.*);

// File: tb/test_pwm_req_quantizer.sv
`timescale 1ns/1ps
module test_pwm_req_quantizer;
    localparam int unsigned LOAD_W = 16;
    localparam int unsigned CYC_W  = LOAD_W + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [CYC_W-1:0]  req_period = '0;
    logic [CYC_W-1:0]  req_duty = '0;
    logic [LOAD_W-1:0] max_count = '0;
    logic              res_valid;
    logic [LOAD_W-1:0] period_load;
    logic [LOAD_W-1:0] duty_load;
    logic              range_err;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pwm_req_quantizer #(.LOAD_W(LOAD_W)) i_pwm_req_quantizer (.*);

    task automatic check(string tag, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // expected outcome, computed from the requirement text
    task automatic model(input longint p, input longint d, input longint m,
                         output bit err, output longint pl, output longint dl,
                         output string tag);
        longint mp, pc, dc;
        mp = m + 2;
        pc = (p > mp) ? mp : p;
        tag = (p > mp) ? "R2" : "R4";
        if (pc < 2) begin
            err = 1; pl = 0; dl = 0; tag = "R3"; return;
        end
        err = 0;
        dc = (d > mp) ? mp : d;
        if (dc > pc) begin dc = pc; tag = {tag, "/R5"}; end
        if (dc == pc) begin dc = pc - 1; tag = {tag, "/R6"}; end
        if (dc < 2) begin dc = pc; tag = {tag, "/R7"}; end
        else if (dc == d) tag = {tag, "/R8"};
        pl = pc - 2;
        dl = dc - 2;
    endtask

    task automatic run(longint p, longint d, longint m);
        bit err; longint pl, dl; string tag;
        logic [LOAD_W-1:0] hp, hd; logic he;
        model(p, d, m, err, pl, dl, tag);
        @(negedge clk);
        req_valid  = 1'b1;
        req_period = CYC_W'(p);
        req_duty   = CYC_W'(d);
        max_count  = LOAD_W'(m);
        @(negedge clk);
        req_valid = 1'b0;
        check({"R1 valid ", tag}, res_valid, 1);
        check({"R3 err ", tag}, range_err, err);
        check({"period ", tag}, period_load, pl);
        check({"duty ", tag}, duty_load, dl);
        hp = period_load; hd = duty_load; he = range_err;
        // idle cycle with disturbed inputs: nothing may change (R9)
        req_period = CYC_W'($urandom);
        req_duty   = CYC_W'($urandom);
        @(negedge clk);
        check("R1 no valid when idle", res_valid, 0);
        check("R9 hold", {he, hp, hd}, {range_err, period_load, duty_load});
    endtask

    initial begin
        void'($urandom(32'd1234));
        #1;
        check("R9 reset valid", res_valid, 0);
        check("R9 reset loads", {range_err, period_load, duty_load}, 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        // directed corners
        run(0, 0, 100);      // R3
        run(1, 1, 100);      // R3
        run(2, 2, 100);      // R6 then R7
        run(3, 3, 100);      // R6 -> 2
        run(3, 1, 100);      // R7
        run(102, 50, 100);   // at max, R4
        run(103, 50, 100);   // R2
        run(5000, 5000, 100); // R2 + R6
        run(50, 80, 100);    // R5
        run(50, 49, 100);    // R8
        run(50, 0, 100);     // R7
        run(10, 200, 0);     // max 0 -> period 2, R7
        run(131071, 131071, 65535); // widest
        // random
        for (int i = 0; i < 400; i++) begin
            longint m, p, d;
            m = (i % 3 == 0) ? longint'($urandom_range(0, 8)) : longint'($urandom_range(0, 65535));
            p = longint'($urandom_range(0, 32'(m + 4)));
            d = (i % 4 == 0) ? p : longint'($urandom_range(0, 32'(p + 3)));
            run(p, d, m);
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule